// File: doc/BRIEF.md
# Grouped Level Interrupt Controller

This block gathers a set of level-sensitive interrupt lines and presents them to a processor as two request outputs: a normal request and a fast request. The sources are arranged in groups of 32. Source n lives in group n/32 at bit n%32. Each group has its own latched pending word and its own enable, mask, route-select and force words. It also has two plain storage words, one for response and one for priority. A global vector word, a base-address word, a protection word and a non-maskable control word complete the map.

The processor reaches the block through a simple 32-bit register port with a read strobe, a write strobe, a word address and a privilege flag. The read path is combinational. A write takes effect on the rising clock edge on which the write strobe is high. In a typical service routine, software reads a pending word, masks it with the enables it keeps, and writes that same value back to clear the bits it handles. A line that is still high sets its bit again one cycle after the clear. A source reaches the output only when its enable bit is 1 and its mask bit is 0. Software normally keeps the mask word equal to the inverse of the enable word.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, irq_o and fiq_o are 0. Every enable word (byte offsets 0x40+4g) reads 0, every mask word (0x50+4g) reads 0xFFFFFFFF, and the vector word (0x00) reads 0.
- R2: A source held high sets pending bit n%32 of group n/32 on the next rising edge. The pending bit stays set after the source falls, until it is cleared.
- R3: A write to the normal pending word (0x10+4g) or to the fast pending word (0x20+4g) clears exactly the pending bits that are 1 in the data and leaves the other bits unchanged. A cleared bit whose source is still high reads 1 again one cycle later.
- R4: irq_o is 1 exactly when some source has pending=1, enable=1, mask=0 and select=0. An enabled bit that is still masked, or an unmasked bit that is not enabled, does not drive irq_o.
- R5: A select bit of 1 (select words at 0x30+4g) routes its source to the fast path. The bit then appears in the fast pending word (0x20+4g) and drives fiq_o. It reads 0 in the normal pending word (0x10+4g) and cannot drive irq_o.
- R6: The vector word (0x00) reads 4 times the lowest source number that drives irq_o, or 0 when irq_o is 0.
- R7: When bit 0 of the protection word (0x08) is 1 and priv_i is 0, reads return 0 and writes are ignored. This includes writes to the protection word itself. Accesses with priv_i=1 still work.
- R8: Reads of unmapped offsets (0x1C, 0x2C, 0x3C through 0x8C, and 0x90 through 0xFC) return 0. Writes to those offsets change no register.
- R9: The base-address word (0x04), the non-maskable control word (0x0C), the response words (0x60+4g) and the priority words (0x80+4g) read back the last value written. The protection word reads back bit 0 only.
- R10: A force bit of 1 (force words at 0x70+4g) sets its pending bit with the source low. The pending bit is set one cycle after the force write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_GRP*32 | Level-sensitive interrupt sources |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 6 | Word address (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| priv_i | input | 1 | Access is privileged |
| rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A pending bit that latches wrongly becomes visible in the pending word on the first read after the edge that should have set or cleared it. That read takes place one cycle after the source or clear stimulus. A wrong gating or select term shows up on irq_o, fiq_o or the vector word in the same cycle as the faulty pending state, because these outputs are combinational from the registers. Wrongly kept protection or a wrongly decoded address shows up as a stored word that differs on the next privileged read-back.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  typedef enum logic [3:0] {
    RK_GLOB  = 4'h0,
    RK_IPEND = 4'h1,
    RK_FPEND = 4'h2,
    RK_SEL   = 4'h3,
    RK_EN    = 4'h4,
    RK_MASK  = 4'h5,
    RK_RESP  = 4'h6,
    RK_FORCE = 4'h7,
    RK_PRIO  = 4'h8
  } reg_kind_e;

  localparam logic [1:0] GW_VEC  = 2'd0;
  localparam logic [1:0] GW_BASE = 2'd1;
  localparam logic [1:0] GW_PROT = 2'd2;
  localparam logic [1:0] GW_NMI  = 2'd3;
endpackage

// File: rtl/intc_group.sv
module intc_group
  import intc_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         we_i,
  input  reg_kind_e    kind_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] sel_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] force_o,
  output logic [W-1:0] resp_o,
  output logic [W-1:0] prio_o
);
  logic [W-1:0] pend_q, clr;

  assign clr = (we_i && (kind_i == RK_IPEND || kind_i == RK_FPEND)) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      sel_o   <= '0;
      en_o    <= '0;
      mask_o  <= '1;
      force_o <= '0;
      resp_o  <= '0;
      prio_o  <= '0;
    end else begin
      // cleared bits stay 0 for one cycle, then re-latch from level/force
      pend_q <= (pend_q | src_i | force_o) & ~clr;
      if (we_i) begin
        unique case (kind_i)
          RK_SEL:   sel_o   <= wdata_i;
          RK_EN:    en_o    <= wdata_i;
          RK_MASK:  mask_o  <= wdata_i;
          RK_FORCE: force_o <= wdata_i;
          RK_RESP:  resp_o  <= wdata_i;
          RK_PRIO:  prio_o  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign pend_o = pend_q;

  // R2
  level_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(src_i & ~clr)) == $past(src_i & ~clr)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr != '0) |=> ((pend_q & $past(clr)) == '0));
endmodule

// File: rtl/intc_first_one.sv
module intc_first_one #(
  parameter int W     = 96,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_GRP = 3,
  localparam int NUM_SRC = NUM_GRP * DATA_W,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               priv_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  logic [NUM_GRP-1:0][DATA_W-1:0] pend_g, sel_g, en_g, mask_g, force_g, resp_g, prio_g;
  logic [NUM_SRC-1:0] pend_a, sel_a, en_a, mask_a, irq_act, fiq_act;
  logic [DATA_W-1:0] base_q, nmi_q, vec_w;
  logic              prot_q, acc_ok, grp_ok, vec_found;
  logic [IDX_W-1:0]  vec_idx;
  logic [1:0]        grp;
  reg_kind_e         kind;
  logic              kind_ok;

  assign grp     = addr_i[1:0];
  assign kind    = reg_kind_e'(addr_i[5:2]);
  assign kind_ok = (addr_i[5:2] >= 4'h1) && (addr_i[5:2] <= 4'h8);
  assign grp_ok  = int'(grp) < NUM_GRP;
  assign acc_ok  = !prot_q || priv_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    intc_group #(.W(DATA_W)) i_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_i[g*DATA_W +: DATA_W]),
      .we_i    (wr_i && acc_ok && kind_ok && (int'(grp) == g)),
      .kind_i  (kind),
      .wdata_i (wdata_i),
      .pend_o  (pend_g[g]),
      .sel_o   (sel_g[g]),
      .en_o    (en_g[g]),
      .mask_o  (mask_g[g]),
      .force_o (force_g[g]),
      .resp_o  (resp_g[g]),
      .prio_o  (prio_g[g])
    );
    assign pend_a[g*DATA_W +: DATA_W] = pend_g[g];
    assign sel_a[g*DATA_W +: DATA_W]  = sel_g[g];
    assign en_a[g*DATA_W +: DATA_W]   = en_g[g];
    assign mask_a[g*DATA_W +: DATA_W] = mask_g[g];
  end

  assign irq_act = pend_a & en_a & ~mask_a & ~sel_a;
  assign fiq_act = pend_a & en_a & ~mask_a & sel_a;
  assign irq_o   = |irq_act;
  assign fiq_o   = |fiq_act;

  intc_first_one #(.W(NUM_SRC)) i_first (
    .vec_i   (irq_act),
    .found_o (vec_found),
    .idx_o   (vec_idx)
  );
  assign vec_w = vec_found ? (DATA_W'(vec_idx) << 2) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      nmi_q  <= '0;
      prot_q <= 1'b0;
    end else if (wr_i && acc_ok && addr_i[5:2] == 4'h0) begin
      unique case (grp)
        GW_BASE: base_q <= wdata_i;
        GW_PROT: prot_q <= wdata_i[0];
        GW_NMI:  nmi_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i && acc_ok) begin
      if (addr_i[5:2] == 4'h0) begin
        unique case (grp)
          GW_VEC:  rdata_o = vec_w;
          GW_BASE: rdata_o = base_q;
          GW_PROT: rdata_o = {{(DATA_W-1){1'b0}}, prot_q};
          default: rdata_o = nmi_q;
        endcase
      end else if (kind_ok && grp_ok) begin
        unique case (kind)
          RK_IPEND: rdata_o = pend_g[grp] & ~sel_g[grp];
          RK_FPEND: rdata_o = pend_g[grp] & sel_g[grp];
          RK_SEL:   rdata_o = sel_g[grp];
          RK_EN:    rdata_o = en_g[grp];
          RK_MASK:  rdata_o = mask_g[grp];
          RK_RESP:  rdata_o = resp_g[grp];
          RK_FORCE: rdata_o = force_g[grp];
          RK_PRIO:  rdata_o = prio_g[grp];
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  // R4
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_a & ~mask_a) == '0) |-> (!irq_o && !fiq_o));

  // R6
  vec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_w == '0));

  // R6
  vec_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_act[vec_idx]);

  // R7
  prot_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && prot_q && !priv_i) |-> (rdata_o == '0));

  // R7
  prot_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && prot_q && !priv_i) |=> (base_q == $past(base_q) && prot_q));
endmodule

// File: tb/test_lvl_irq_ctrl.sv
module test_lvl_irq_ctrl;
  localparam int NG = 3;
  localparam int NS = NG * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          rd = 1'b0, wr = 1'b0, priv = 1'b1;
  logic [5:0]    addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic          irq, fiq;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  lvl_irq_ctrl #(.NUM_GRP(NG)) i_lvl_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .priv_i(priv), .rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] off, input logic [31:0] d);
    addr = off[7:2]; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] off, output logic [31:0] d);
    addr = off[7:2]; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic chk_rd(input string req, input logic [7:0] off, input logic [31:0] exp);
    logic [31:0] d;
    rd_reg(off, d);
    chk(req, d, exp);
  endtask

  task automatic cleanup();
    src = '0;
    for (int g = 0; g < NG; g++) begin
      wr_reg(8'h70 + 8'(4*g), 32'h0);
      wr_reg(8'h30 + 8'(4*g), 32'h0);
      wr_reg(8'h40 + 8'(4*g), 32'h0);
      wr_reg(8'h50 + 8'(4*g), 32'hFFFF_FFFF);
    end
    for (int g = 0; g < NG; g++) wr_reg(8'h10 + 8'(4*g), 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 fiq", {31'b0, fiq}, 32'h0);
    for (int g = 0; g < NG; g++) begin
      chk_rd("R1 enable", 8'h40 + 8'(4*g), 32'h0);
      chk_rd("R1 mask", 8'h50 + 8'(4*g), 32'hFFFF_FFFF);
    end
    chk_rd("R1 vector", 8'h00, 32'h0);
  endtask

  task automatic t_level();
    src[5] = 1'b1; src[40] = 1'b1; src[95] = 1'b1;
    tick();
    chk_rd("R2 grp0", 8'h10, 32'h0000_0020);
    chk_rd("R2 grp1", 8'h14, 32'h0000_0100);
    chk_rd("R2 grp2", 8'h18, 32'h8000_0000);
    src[95] = 1'b0;
    tick();
    chk_rd("R2 held", 8'h18, 32'h8000_0000);
    chk("R4 no enable", {31'b0, irq}, 32'h0);
    wr_reg(8'h44, 32'h0000_0100);
    chk("R4 masked", {31'b0, irq}, 32'h0);
    wr_reg(8'h54, ~32'h0000_0100);
    chk("R4 active", {31'b0, irq}, 32'h1);
    chk_rd("R6 vec 40", 8'h00, 32'd160);
    wr_reg(8'h50, ~32'h0000_0020);
    chk("R4 unmask only", {31'b0, irq}, 32'h1);
    chk_rd("R6 vec unchanged", 8'h00, 32'd160);
    wr_reg(8'h40, 32'h0000_0020);
    chk_rd("R6 vec 5", 8'h00, 32'd20);
  endtask

  task automatic t_w1c();
    wr_reg(8'h10, 32'h0000_0020);
    chk_rd("R3 cleared", 8'h10, 32'h0);
    tick();
    chk_rd("R3 relatch", 8'h10, 32'h0000_0020);
    src[40] = 1'b0; src[41] = 1'b1;
    tick();
    src[41] = 1'b0;
    tick();
    chk_rd("R3 two bits", 8'h14, 32'h0000_0300);
    wr_reg(8'h14, 32'h0000_0100);
    chk_rd("R3 partial", 8'h14, 32'h0000_0200);
    tick();
    chk_rd("R3 no relatch", 8'h14, 32'h0000_0200);
    src[5] = 1'b0;
    tick();
    wr_reg(8'h10, 32'h0000_0020);
    tick();
    chk_rd("R3 grp0 empty", 8'h10, 32'h0);
    chk("R4 idle", {31'b0, irq}, 32'h0);
    chk_rd("R6 vec idle", 8'h00, 32'h0);
    cleanup();
  endtask

  task automatic t_force();
    wr_reg(8'h78, 32'h0000_0001);
    tick();
    chk_rd("R10 forced", 8'h18, 32'h0000_0001);
    wr_reg(8'h78, 32'h0);
    wr_reg(8'h18, 32'h0000_0001);
    tick();
    chk_rd("R10 released", 8'h18, 32'h0);
  endtask

  task automatic t_select();
    src[67] = 1'b1;
    wr_reg(8'h48, 32'h0000_0008);
    wr_reg(8'h58, ~32'h0000_0008);
    wr_reg(8'h38, 32'h0000_0008);
    chk("R5 fiq", {31'b0, fiq}, 32'h1);
    chk("R5 no irq", {31'b0, irq}, 32'h0);
    chk_rd("R5 fast pend", 8'h28, 32'h0000_0008);
    chk_rd("R5 normal pend", 8'h18, 32'h0);
    chk_rd("R6 vec fiq", 8'h00, 32'h0);
    wr_reg(8'h38, 32'h0);
    chk("R5 back irq", {31'b0, irq}, 32'h1);
    chk("R5 back fiq", {31'b0, fiq}, 32'h0);
    chk_rd("R6 vec 67", 8'h00, 32'd268);
    cleanup();
  endtask

  task automatic t_store();
    wr_reg(8'h04, 32'hDEAD_BEEF);
    wr_reg(8'h0C, 32'h0000_00A5);
    for (int g = 0; g < NG; g++) begin
      wr_reg(8'h60 + 8'(4*g), 32'h1111_0000 + 32'(g));
      wr_reg(8'h80 + 8'(4*g), 32'h2222_0000 + 32'(g));
    end
    chk_rd("R9 base", 8'h04, 32'hDEAD_BEEF);
    chk_rd("R9 nmi", 8'h0C, 32'h0000_00A5);
    for (int g = 0; g < NG; g++) begin
      chk_rd("R9 resp", 8'h60 + 8'(4*g), 32'h1111_0000 + 32'(g));
      chk_rd("R9 prio", 8'h80 + 8'(4*g), 32'h2222_0000 + 32'(g));
    end
    wr_reg(8'h08, 32'hFFFF_FFFE);
    chk_rd("R9 prot bit0", 8'h08, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [7:0] offs [4] = '{8'h1C, 8'h8C, 8'hC0, 8'hFC};
    src[0] = 1'b1;
    tick();
    foreach (offs[i]) wr_reg(offs[i], 32'hFFFF_FFFF);
    foreach (offs[i]) chk_rd("R8 read zero", offs[i], 32'h0);
    chk_rd("R8 base kept", 8'h04, 32'hDEAD_BEEF);
    chk_rd("R8 pend kept", 8'h10, 32'h0000_0001);
    chk_rd("R8 prio kept", 8'h88, 32'h2222_0002);
    cleanup();
  endtask

  task automatic t_protect();
    wr_reg(8'h08, 32'h1);
    chk_rd("R7 prot set", 8'h08, 32'h1);
    priv = 1'b0;
    wr_reg(8'h04, 32'h1234_5678);
    wr_reg(8'h08, 32'h0);
    wr_reg(8'h40, 32'hFFFF_FFFF);
    chk_rd("R7 unpriv read", 8'h04, 32'h0);
    priv = 1'b1;
    chk_rd("R7 base kept", 8'h04, 32'hDEAD_BEEF);
    chk_rd("R7 prot kept", 8'h08, 32'h1);
    chk_rd("R7 enable kept", 8'h40, 32'h0);
    wr_reg(8'h08, 32'h0);
    priv = 1'b0;
    chk_rd("R7 open read", 8'h04, 32'hDEAD_BEEF);
    priv = 1'b1;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_level();
    t_w1c();
    t_force();
    t_select();
    t_store();
    t_unmapped();
    t_protect();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule